// File: doc/BRIEF.md
# Eight-Pin Bidirectional I/O Port with Pull-up Control

This block is an 8-bit general-purpose I/O port. Each pin can be set as an input or an output through a direction register. A second register holds the value driven on output pins. On input pins the same register bit turns on the pin's pull-up. The pad levels come back through a two-flop synchronizer and can be read on a small register bus. The pad itself is modelled as three signals per pin: output enable, output value and pull-up enable.

Peripherals can take over single pins through override inputs. An override carries its own output enable and output value, and wins over the port registers. A pin marked as an analog input is never driven by the digital side and gets no software pull-up. A global input switches off every software pull-up.

While the debug interface is enabled, the pull-ups on three test pins (bits 2, 3 and 5) are forced on. This holds even during reset. Reset is asynchronous: every pin stops driving the moment reset goes low, with no clock edge needed.

Top module: `gpio_port_top`

## Requirements
- R1: After reset, the direction register (address 0) and the data register (address 1) read 0x00, and `pad_oe` and `pad_pu` are 0x00 while `dbg_en` is low.
- R2: A write takes effect at the clock edge where `wr_en` is high. A write to address 0 loads direction and a write to address 1 loads data. A write to address 2 or 3 changes neither register. Reads at address 0 or 1 return the register, and reads at address 3 return 0x00.
- R3: With no override and no analog select, `pad_oe` equals the direction register (1 = output) and `pad_out` equals the data register.
- R4: A software pull-up is on for a pin only when all three of these hold: the pin is not driven, its data bit is 1, and `pu_disable` is low.
- R5: When `pu_disable` is high, every pull-up is off except the ones forced by `dbg_en`.
- R6: A pin with `alt_sel` set takes its output enable from `alt_oe` and its output value from `alt_out`, whatever the direction and data registers hold.
- R7: A pin with `analog_en` set has `pad_oe` low and no software pull-up, even if an override asks to drive it.
- R8: While `rst_n` is low, `pad_oe` is 0x00 at once, with no clock edge needed. Both registers are cleared.
- R9: While `dbg_en` is high, `pad_pu` bits 2, 3 and 5 (mask 0x2C) are 1. This holds even during reset and even with `pu_disable` high.
- R10: A read at address 2 returns `pad_in` as sampled two rising clock edges earlier. After only one edge it still returns the older value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 = direction, 1 = data, 2 = pin input |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pad_in | input | 8 | Pad levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |
| pad_pu | output | 8 | Pad pull-up enables |
| alt_sel | input | 8 | Per-pin peripheral override select |
| alt_oe | input | 8 | Override output enable |
| alt_out | input | 8 | Override output value |
| analog_en | input | 8 | Per-pin analog input select |
| pu_disable | input | 1 | Global software pull-up disable |
| dbg_en | input | 1 | Debug interface enable |

## Verification
Two functions can act in the same cycle: the asynchronous reset and the pull-ups forced by debug enable. The bench makes this happen by first setting every pin as an output. It then drops `rst_n` and raises `dbg_en` together, in the middle of a clock period. Before the next clock edge it checks that all pins have stopped driving and that exactly the three forced pull-ups are on. After reset is released, reading the registers back shows they were cleared.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR  = 2'd0,
        REG_DATA = 2'd1,
        REG_PIN  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] rdata,
    output logic [W-1:0] dir_o,
    output logic [W-1:0] data_o
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] data;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                REG_DIR:  st_d.dir  = wdata;
                REG_DATA: st_d.data = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_o  = st_q.dir;
    assign data_o = st_q.data;

    always_comb begin
        case (sel)
            REG_DIR:  rdata = st_q.dir;
            REG_DATA: rdata = st_q.data;
            REG_PIN:  rdata = pin_sync;
            default:  rdata = '0;
        endcase
    end

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_DIR) |=> (dir_o == $past(wdata))); // R2
    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_DATA) |=> (data_o == $past(wdata))); // R2
    AST_RO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == REG_PIN || sel == REG_NONE)) |=> ($stable(dir_o) && $stable(data_o))); // R2
endmodule

// File: rtl/gpio_port_sync.sv
`timescale 1ns/1ps
module gpio_port_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.meta   = async_in;
        sy_d.stable = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign sync_out = sy_q.stable;
endmodule

// File: rtl/gpio_port_pad_ctrl.sv
`timescale 1ns/1ps
module gpio_port_pad_ctrl #(
    parameter int           W        = 8,
    parameter logic [W-1:0] DBG_MASK = 8'h2C
) (
    input  logic         rst_n,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] data,
    input  logic [W-1:0] alt_sel,
    input  logic [W-1:0] alt_oe,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] analog_en,
    input  logic         pu_disable,
    input  logic         dbg_en,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);
    logic [W-1:0] drive_req;

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign drive_req[i] = alt_sel[i] ? alt_oe[i] : dir[i];
        assign pad_out[i]   = alt_sel[i] ? alt_out[i] : data[i];
        assign pad_oe[i]    = rst_n & ~analog_en[i] & drive_req[i];
        assign pad_pu[i]    = (dbg_en & DBG_MASK[i])
                            | (rst_n & ~pu_disable & ~analog_en[i] & ~drive_req[i] & data[i]);
    end

    always_comb begin
        AST_RST_TRISTATE: assert (rst_n || pad_oe == '0); // R8
        AST_ANALOG_QUIET: assert ((pad_oe & analog_en) == '0); // R7
        AST_DBG_FORCED_PU: assert (!dbg_en || (pad_pu & DBG_MASK) == DBG_MASK); // R9
        AST_PU_DISABLE: assert (!pu_disable || (pad_pu & ~(dbg_en ? DBG_MASK : '0)) == '0); // R5
        AST_PU_INPUT_ONLY: assert ((pad_pu & pad_oe & ~DBG_MASK) == '0); // R4
    end
endmodule

// File: rtl/gpio_port_top.sv
`timescale 1ns/1ps
module gpio_port_top
    import gpio_port_pkg::*;
#(
    parameter int           W        = 8,
    parameter logic [W-1:0] DBG_MASK = 8'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_pu,
    input  logic [W-1:0]      alt_sel,
    input  logic [W-1:0]      alt_oe,
    input  logic [W-1:0]      alt_out,
    input  logic [W-1:0]      analog_en,
    input  logic              pu_disable,
    input  logic              dbg_en
);
    logic [W-1:0] pin_sync;
    logic [W-1:0] dir_q;
    logic [W-1:0] data_q;

    gpio_port_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_port_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel      (reg_sel_e'(addr)),
        .wdata    (wdata),
        .pin_sync (pin_sync),
        .rdata    (rdata),
        .dir_o    (dir_q),
        .data_o   (data_q)
    );

    gpio_port_pad_ctrl #(.W(W), .DBG_MASK(DBG_MASK)) u_pad (
        .rst_n      (rst_n),
        .dir        (dir_q),
        .data       (data_q),
        .alt_sel    (alt_sel),
        .alt_oe     (alt_oe),
        .alt_out    (alt_out),
        .analog_en  (analog_en),
        .pu_disable (pu_disable),
        .dbg_en     (dbg_en),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pad_pu     (pad_pu)
    );

    AST_OVERRIDE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_sel == '1 && analog_en == '0) |-> (pad_oe == alt_oe)); // R6
endmodule

// File: tb/gpio_port_top_tb.sv
`timescale 1ns/1ps
module gpio_port_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_oe, pad_out, pad_pu;
    logic [7:0] alt_sel = 8'h00, alt_oe = 8'h00, alt_out = 8'h00, analog_en = 8'h00;
    logic       pu_disable = 1'b0;
    logic       dbg_en = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu), .alt_sel(alt_sel), .alt_oe(alt_oe), .alt_out(alt_out),
        .analog_en(analog_en), .pu_disable(pu_disable), .dbg_en(dbg_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); check("R1 dir after reset", v, 8'h00);
        rd(2'd1, v); check("R1 data after reset", v, 8'h00);
        check("R1 pad_oe after reset", pad_oe, 8'h00);
        check("R1 pad_pu after reset", pad_pu, 8'h00);
    endtask

    task automatic t_regs_and_drive();
        logic [7:0] v;
        wr(2'd0, 8'hF0);
        wr(2'd1, 8'hA5);
        rd(2'd0, v); check("R2 dir readback", v, 8'hF0);
        rd(2'd1, v); check("R2 data readback", v, 8'hA5);
        rd(2'd3, v); check("R2 unused address reads zero", v, 8'h00);
        check("R3 pad_oe follows dir", pad_oe, 8'hF0);
        check("R3 pad_out follows data", pad_out, 8'hA5);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'h3C);
        rd(2'd0, v); check("R2 read-only write keeps dir", v, 8'hF0);
        rd(2'd1, v); check("R2 read-only write keeps data", v, 8'hA5);
    endtask

    task automatic t_pullups();
        #1;
        check("R4 pull-up on undriven pins with data 1", pad_pu, 8'h05);
        pu_disable = 1'b1; #1;
        check("R5 global disable clears pull-ups", pad_pu, 8'h00);
        dbg_en = 1'b1; #1;
        check("R9 forced pull-ups survive global disable", pad_pu, 8'h2C);
        pu_disable = 1'b0; #1;
        check("R9 forced plus software pull-ups", pad_pu, 8'h2D);
        dbg_en = 1'b0; #1;
        check("R4 pull-ups back to software set", pad_pu, 8'h05);
    endtask

    task automatic t_override();
        alt_sel = 8'h03; alt_oe = 8'h01; alt_out = 8'h01; #1;
        check("R6 override output enable", pad_oe, 8'hF1);
        check("R6 override output value", pad_out & pad_oe, 8'hA1);
        check("R4 overridden output loses pull-up", pad_pu, 8'h04);
        alt_sel = 8'hFF; alt_oe = 8'h0F; alt_out = 8'h5A; #1;
        check("R6 full override ignores dir", pad_oe, 8'h0F);
        check("R6 full override ignores data", pad_out, 8'h5A);
        alt_sel = 8'h03; alt_oe = 8'h01; alt_out = 8'h01; #1;
    endtask

    task automatic t_analog();
        analog_en = 8'h81; #1;
        check("R7 analog pins not driven", pad_oe, 8'h70);
        analog_en = 8'h04; #1;
        check("R7 analog pin loses pull-up", pad_pu, 8'h00);
        analog_en = 8'h00;
        alt_sel = 8'h00; alt_oe = 8'h00; alt_out = 8'h00; #1;
    endtask

    task automatic t_sync();
        logic [7:0] v;
        @(negedge clk); pad_in = 8'h5A;
        @(negedge clk);
        rd(2'd2, v); check("R10 one edge still old", v, 8'h00);
        @(negedge clk);
        rd(2'd2, v); check("R10 two edges new value", v, 8'h5A);
        @(negedge clk); pad_in = 8'hC3;
        @(negedge clk); @(negedge clk);
        rd(2'd2, v); check("R10 second pattern", v, 8'hC3);
    endtask

    task automatic t_async_reset();
        logic [7:0] v;
        wr(2'd0, 8'hFF);
        #1; check("R3 all pins driven", pad_oe, 8'hFF);
        @(posedge clk); #2;
        rst_n = 1'b0; dbg_en = 1'b1; pu_disable = 1'b1;
        #1;
        check("R8 tri-state without clock edge", pad_oe, 8'h00);
        check("R9 forced pull-ups during reset", pad_pu, 8'h2C);
        @(negedge clk);
        rst_n = 1'b1; dbg_en = 1'b0; pu_disable = 1'b0;
        rd(2'd0, v); check("R8 dir cleared by reset", v, 8'h00);
        rd(2'd1, v); check("R8 data cleared by reset", v, 8'h00);
        check("R1 no pull-ups after reset", pad_pu, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_regs_and_drive();
        t_pullups();
        t_override();
        t_analog();
        t_sync();
        t_async_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule